// File: doc/BRIEF.md
# Pairwise Register Hazard Classifier

This block takes the register fields of two instructions in flight, an older one and a younger one. It reports which data dependencies link them. Each instruction supplies one destination index and two source indices, and each field has its own valid bit. The block works only on indices that have already been extracted from the instructions. It does not decode instructions, choose a stall policy or select forwarding paths.

The block raises three separate flags:
- read-after-write: the younger instruction reads a register that the older one writes. The younger instruction must not use that operand until the older result exists.
- write-after-read: the younger instruction writes a register that the older one reads.
- write-after-write: both instructions write the same register.

Two instructions that only read a common register are independent and raise no flag. The block also produces a stall request. It is the OR of the three flags, each masked by its own enable input, so the surrounding control can ignore a kind of dependency it already resolves by another means. A parameter selects either same-cycle outputs or outputs registered by one clock.

Top module: `reg_hazard_classifier`

## Requirements
- R1: `raw` is 1 when `old_wr_vld` is set and `old_wr_idx` equals `new_rd0_idx` with `new_rd0_vld` set, or equals `new_rd1_idx` with `new_rd1_vld` set. Every index value counts, including 0 and the highest index.
- R2: `war` is 1 when `new_wr_vld` is set and `new_wr_idx` equals `old_rd0_idx` with `old_rd0_vld` set, or equals `old_rd1_idx` with `old_rd1_vld` set.
- R3: `waw` is 1 when `old_wr_vld` and `new_wr_vld` are both set and `old_wr_idx` equals `new_wr_idx`.
- R4: Sources shared between the two instructions, with no write involved in the match, raise no flag and no stall.
- R5: A field whose valid bit is 0 never takes part in a match, whatever its index value.
- R6: The flags are independent, so any combination of them, all three included, may be 1 at the same time.
- R7: `stall` equals (`raw` AND `en_raw`) OR (`war` AND `en_war`) OR (`waw` AND `en_waw`). The enables affect only `stall` and never the three flags.
- R8: With `PIPELINED`=1 (the default), the outputs reflect the inputs sampled at the previous rising clock edge, and they are 0 while `rst_n` is low. With `PIPELINED`=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registered mode |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| old_wr_idx | input | IDX_W | Register written by the older instruction |
| old_wr_vld | input | 1 | The older instruction writes a register |
| old_rd0_idx | input | IDX_W | First register read by the older instruction |
| old_rd0_vld | input | 1 | The first source of the older instruction is used |
| old_rd1_idx | input | IDX_W | Second register read by the older instruction |
| old_rd1_vld | input | 1 | The second source of the older instruction is used |
| new_wr_idx | input | IDX_W | Register written by the younger instruction |
| new_wr_vld | input | 1 | The younger instruction writes a register |
| new_rd0_idx | input | IDX_W | First register read by the younger instruction |
| new_rd0_vld | input | 1 | The first source of the younger instruction is used |
| new_rd1_idx | input | IDX_W | Second register read by the younger instruction |
| new_rd1_vld | input | 1 | The second source of the younger instruction is used |
| en_raw | input | 1 | Lets read-after-write contribute to the stall |
| en_war | input | 1 | Lets write-after-read contribute to the stall |
| en_waw | input | 1 | Lets write-after-write contribute to the stall |
| raw | output | 1 | Read-after-write dependency found |
| war | output | 1 | Write-after-read dependency found |
| waw | output | 1 | Write-after-write dependency found |
| stall | output | 1 | Combined stall request |

## Verification
The assertions are checked on every cycle. They cover:
- each flag rising one cycle after its matching pair of valid fields, or in the same cycle in the unregistered mode;
- the absence of flags when only sources are shared or when the relevant valid bits are clear;
- the rule that a stall never appears without a flag;
- the rule that a stall never appears with every enable off.

Only the directed scenarios can show:
- that a flag stays low when indices differ;
- that a cleared enable removes its own kind from the stall while the flag itself stays set;
- the exact one-cycle lag of the registered outputs and their zero value during reset.

// File: rtl/reg_hazard_classifier.sv
module reg_hazard_classifier #(
  parameter int IDX_W     = 5,
  parameter bit PIPELINED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] old_wr_idx,
  input  logic             old_wr_vld,
  input  logic [IDX_W-1:0] old_rd0_idx,
  input  logic             old_rd0_vld,
  input  logic [IDX_W-1:0] old_rd1_idx,
  input  logic             old_rd1_vld,
  input  logic [IDX_W-1:0] new_wr_idx,
  input  logic             new_wr_vld,
  input  logic [IDX_W-1:0] new_rd0_idx,
  input  logic             new_rd0_vld,
  input  logic [IDX_W-1:0] new_rd1_idx,
  input  logic             new_rd1_vld,
  input  logic             en_raw,
  input  logic             en_war,
  input  logic             en_waw,
  output logic             raw,
  output logic             war,
  output logic             waw,
  output logic             stall
);

  function automatic logic hit(input logic [IDX_W-1:0] a, input logic av,
                               input logic [IDX_W-1:0] b, input logic bv);
    return av && bv && (a == b);
  endfunction

  logic raw_c, war_c, waw_c, stall_c;

  assign raw_c = hit(old_wr_idx, old_wr_vld, new_rd0_idx, new_rd0_vld)
               | hit(old_wr_idx, old_wr_vld, new_rd1_idx, new_rd1_vld);
  assign war_c = hit(old_rd0_idx, old_rd0_vld, new_wr_idx, new_wr_vld)
               | hit(old_rd1_idx, old_rd1_vld, new_wr_idx, new_wr_vld);
  assign waw_c = hit(old_wr_idx, old_wr_vld, new_wr_idx, new_wr_vld);

  assign stall_c = (raw_c & en_raw) | (war_c & en_war) | (waw_c & en_waw);

  generate
    if (PIPELINED) begin : g_reg
      logic [3:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= {raw_c, war_c, waw_c, stall_c};
      end
      assign {raw, war, waw, stall} = q;
    end else begin : g_comb
      assign {raw, war, waw, stall} = {raw_c, war_c, waw_c, stall_c};
    end
  endgenerate

endmodule

// File: rtl/reg_hazard_classifier_chk.sv
module reg_hazard_classifier_chk #(
  parameter int IDX_W     = 5,
  parameter bit PIPELINED = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] old_wr_idx,
  input logic             old_wr_vld,
  input logic [IDX_W-1:0] old_rd0_idx,
  input logic             old_rd0_vld,
  input logic [IDX_W-1:0] old_rd1_idx,
  input logic             old_rd1_vld,
  input logic [IDX_W-1:0] new_wr_idx,
  input logic             new_wr_vld,
  input logic [IDX_W-1:0] new_rd0_idx,
  input logic             new_rd0_vld,
  input logic [IDX_W-1:0] new_rd1_idx,
  input logic             new_rd1_vld,
  input logic             en_raw,
  input logic             en_war,
  input logic             en_waw,
  input logic             raw,
  input logic             war,
  input logic             waw,
  input logic             stall
);

  logic no_writes;
  assign no_writes = !old_wr_vld && !new_wr_vld;

  AST_STALL_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (raw || war || waw)); // R7

  generate
    if (PIPELINED) begin : g_p
      AST_RAW_RD0: assert property (@(posedge clk) disable iff (!rst_n)
        (old_wr_vld && new_rd0_vld && old_wr_idx == new_rd0_idx) |=> raw); // R1
      AST_WAR_RD1: assert property (@(posedge clk) disable iff (!rst_n)
        (new_wr_vld && old_rd1_vld && new_wr_idx == old_rd1_idx) |=> war); // R2
      AST_WAW_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (old_wr_vld && new_wr_vld && old_wr_idx == new_wr_idx) |=> waw); // R3
      AST_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        no_writes |=> !(raw || war || waw || stall)); // R4
      AST_NO_OLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !old_wr_vld |=> !raw && !waw); // R5
      AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_raw && !en_war && !en_waw) |=> !stall); // R7
    end else begin : g_c
      AST_RAW_RD0: assert property (@(posedge clk) disable iff (!rst_n)
        (old_wr_vld && new_rd0_vld && old_wr_idx == new_rd0_idx) |-> raw); // R1
      AST_WAR_RD1: assert property (@(posedge clk) disable iff (!rst_n)
        (new_wr_vld && old_rd1_vld && new_wr_idx == old_rd1_idx) |-> war); // R2
      AST_WAW_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (old_wr_vld && new_wr_vld && old_wr_idx == new_wr_idx) |-> waw); // R3
      AST_READS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        no_writes |-> !(raw || war || waw || stall)); // R4
      AST_NO_OLD_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !old_wr_vld |-> !raw && !waw); // R5
      AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_raw && !en_war && !en_waw) |-> !stall); // R7
    end
  endgenerate

endmodule

bind reg_hazard_classifier reg_hazard_classifier_chk #(
  .IDX_W(IDX_W), .PIPELINED(PIPELINED)
) u_chk (.*);

// File: tb/reg_hazard_classifier_bench.sv
`timescale 1ns/1ps
module reg_hazard_classifier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] owi, or0, or1, nwi, nr0, nr1;
  logic owv, or0v, or1v, nwv, nr0v, nr1v;
  logic en_raw, en_war, en_waw;
  logic raw, war, waw, stall;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_hazard_classifier u_reg_hazard_classifier (
    .clk(clk), .rst_n(rst_n),
    .old_wr_idx(owi), .old_wr_vld(owv),
    .old_rd0_idx(or0), .old_rd0_vld(or0v),
    .old_rd1_idx(or1), .old_rd1_vld(or1v),
    .new_wr_idx(nwi), .new_wr_vld(nwv),
    .new_rd0_idx(nr0), .new_rd0_vld(nr0v),
    .new_rd1_idx(nr1), .new_rd1_vld(nr1v),
    .en_raw(en_raw), .en_war(en_war), .en_waw(en_waw),
    .raw(raw), .war(war), .waw(waw), .stall(stall)
  );

  task automatic check(string req, logic [3:0] exp);
    logic [3:0] got = {raw, war, waw, stall};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {raw,war,waw,stall} actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic set_old(logic [W-1:0] w, logic wv, logic [W-1:0] a, logic av,
                         logic [W-1:0] b, logic bv);
    owi = w; owv = wv; or0 = a; or0v = av; or1 = b; or1v = bv;
  endtask

  task automatic set_new(logic [W-1:0] w, logic wv, logic [W-1:0] a, logic av,
                         logic [W-1:0] b, logic bv);
    nwi = w; nwv = wv; nr0 = a; nr0v = av; nr1 = b; nr1v = bv;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    set_old(5'd3, 1, 5'd3, 1, 5'd3, 1);
    set_new(5'd3, 1, 5'd3, 1, 5'd3, 1);
    {en_raw, en_war, en_waw} = 3'b111;
    step();
    check("R8 outputs zero in reset", 4'b0000);
    rst_n = 1'b1;
    step();
    check("R8 first result after reset", 4'b1111);
  endtask

  task automatic t_raw();
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd3, 1, 5'd4, 1);
    step(); check("R1 raw on first source", 4'b1001);
    set_new(5'd7, 1, 5'd4, 1, 5'd3, 1);
    step(); check("R1 raw on second source", 4'b1001);
    set_old(5'd31, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd31, 1, 5'd4, 1);
    step(); check("R1 raw at top index", 4'b1001);
    set_old(5'd0, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd4, 1, 5'd0, 1);
    step(); check("R1 raw at index zero", 4'b1001);
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd4, 1, 5'd5, 1);
    step(); check("R1 no match when indices differ", 4'b0000);
  endtask

  task automatic t_war();
    set_old(5'd10, 1, 5'd8, 1, 5'd9, 1);
    set_new(5'd9, 1, 5'd11, 1, 5'd12, 1);
    step(); check("R2 war on second old source", 4'b0101);
    set_new(5'd8, 1, 5'd11, 1, 5'd12, 1);
    step(); check("R2 war on first old source", 4'b0101);
  endtask

  task automatic t_waw();
    set_old(5'd15, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd15, 1, 5'd4, 1, 5'd6, 1);
    step(); check("R3 waw same destination", 4'b0011);
  endtask

  task automatic t_rar();
    set_old(5'd20, 1, 5'd5, 1, 5'd6, 1);
    set_new(5'd21, 1, 5'd5, 1, 5'd6, 1);
    step(); check("R4 shared sources raise nothing", 4'b0000);
  endtask

  task automatic t_invalid();
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd3, 0, 5'd3, 0);
    step(); check("R5 invalid young sources", 4'b0000);
    set_old(5'd9, 0, 5'd12, 0, 5'd12, 0);
    set_new(5'd9, 1, 5'd9, 1, 5'd4, 1);
    step(); check("R5 invalid old fields", 4'b0000);
    set_old(5'd9, 1, 5'd9, 1, 5'd4, 1);
    set_new(5'd9, 0, 5'd1, 1, 5'd2, 1);
    step(); check("R5 invalid young destination", 4'b0000);
  endtask

  task automatic t_multi();
    set_old(5'd3, 1, 5'd3, 1, 5'd2, 1);
    set_new(5'd3, 1, 5'd3, 1, 5'd4, 1);
    step(); check("R6 all three flags together", 4'b1111);
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    step(); check("R6 raw with waw", 4'b1011);
  endtask

  task automatic t_enables();
    set_old(5'd3, 1, 5'd3, 1, 5'd2, 1);
    set_new(5'd3, 1, 5'd3, 1, 5'd4, 1);
    {en_raw, en_war, en_waw} = 3'b011;
    step(); check("R7 raw masked, others still stall", 4'b1111);
    {en_raw, en_war, en_waw} = 3'b000;
    step(); check("R7 all masked, flags kept", 4'b1110);
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd3, 1, 5'd4, 1);
    {en_raw, en_war, en_waw} = 3'b011;
    step(); check("R7 raw alone masked", 4'b1000);
    set_old(5'd10, 1, 5'd8, 1, 5'd9, 1);
    set_new(5'd9, 1, 5'd11, 1, 5'd12, 1);
    {en_raw, en_war, en_waw} = 3'b101;
    step(); check("R7 war alone masked", 4'b0100);
    set_old(5'd15, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd15, 1, 5'd4, 1, 5'd6, 1);
    {en_raw, en_war, en_waw} = 3'b110;
    step(); check("R7 waw alone masked", 4'b0010);
    {en_raw, en_war, en_waw} = 3'b001;
    step(); check("R7 waw enabled stalls", 4'b0011);
    {en_raw, en_war, en_waw} = 3'b111;
  endtask

  task automatic t_latency();
    set_old(5'd3, 1, 5'd1, 1, 5'd2, 1);
    set_new(5'd7, 1, 5'd3, 1, 5'd4, 1);
    step(); check("R8 raw registered", 4'b1001);
    set_new(5'd7, 1, 5'd5, 1, 5'd4, 1);
    #1; check("R8 output holds until next edge", 4'b1001);
    step(); check("R8 new inputs after one edge", 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    set_old('0, 0, '0, 0, '0, 0);
    set_new('0, 0, '0, 0, '0, 0);
    {en_raw, en_war, en_waw} = 3'b111;
    @(negedge clk);
    t_reset();
    t_raw();
    t_war();
    t_waw();
    t_rar();
    t_invalid();
    t_multi();
    t_enables();
    t_latency();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule